// File: doc/BRIEF.md
# Synthesizer Divider Chain with Test Observation Select

This block holds the digital dividers of a clock synthesizer and the path that lets a tester observe them. It divides a reference clock down for the phase comparator. It divides the oscillator-rate clock by a programmable feedback ratio and then halves it. It divides the same clock by a coded output ratio to make the main output, and it drives a single test pin from one of eight selectable sources. The phase comparator, the oscillator and the analog drivers sit outside the block.

All source clocks are modelled as single-cycle enable pulses on one system clock. Each pulse stands for one period of that source. Every derived clock is a level that toggles once per K counted source pulses when its ratio is K. This keeps every ratio exact, divide-by-one included, and gives every derived output an even duty cycle in the model. A level changes at the system clock edge that closes the cycle in which its final counted pulse was presented.

Changing a ratio, or changing the source of the programmable dividers, restarts only the counters that change affects. The output level is kept as it was, so no output phase comes out shorter than the new half period. One test code moves both programmable dividers from the oscillator pulses to the serial-clock pulses, so the chain can be exercised at tester speed.

Top module: `synth_div_chain`

## Requirements
- R1: After reset, `ref_div_clk`, `fb_clk` and the internal output level are low, and every counter is at zero.
- R2: `ref_div_clk` toggles once every 16 `ref_pulse` pulses, and at no other time.
- R3: `fb_clk` toggles once every 2·M pulses of the active divider source, where M is `m_val` read as unsigned. A value of zero divides as 512.
- R4: `n_code` sets the output ratio: 2'b00 toggles the output every 2 source pulses, 2'b01 every 4, 2'b10 every 8 and 2'b11 on every pulse.
- R5: While `out_en` is low, `out_clk` is low and the dividers keep counting. When `out_en` rises, `out_clk` shows the running internal level in the same cycle.
- R6: `test_out` follows `test_sel`: 3'b000 `shift_out`, 3'b001 constant 1, 3'b010 `ref_div_clk`, 3'b011 `fb_clk`, 3'b100 `out_clk`, 3'b101 constant 0, 3'b110 `fb_clk` (serial-clock sourced), 3'b111 the output divided by 4.
- R7: With `test_sel` = 3'b110, the feedback and output dividers count `sclk_pulse` and ignore `vco_pulse`. With any other code they count `vco_pulse` and ignore `sclk_pulse`.
- R8: In a cycle where `m_val`, `n_code` or the divider source selection differs from the previous cycle, the affected counters clear and levels are held. A source pulse in that cycle is not counted, and the next toggle comes exactly K counted pulses later.
- R9: A derived level changes at the first clock edge after the cycle in which its K-th pulse is presented.
- R10: With `test_sel` = 3'b111, `test_out` toggles once every 4·N source pulses, where N is the output ratio. It counts even while `out_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 1 | One pulse per reference clock period |
| vco_pulse | input | 1 | One pulse per oscillator clock period |
| sclk_pulse | input | 1 | One pulse per serial clock period |
| m_val | input | 9 | Feedback ratio M |
| n_code | input | 2 | Output ratio code |
| test_sel | input | 3 | Test observation select |
| shift_out | input | 1 | Serial shift register output bit |
| out_en | input | 1 | Main output enable, active high |
| ref_div_clk | output | 1 | Reference divided by 16 |
| fb_clk | output | 1 | Feedback clock, source / M / 2 |
| out_clk | output | 1 | Main output clock, source / N, gated |
| test_out | output | 1 | Selected test observation signal |

## Verification
Each derived level is due one system cycle after the cycle that carries its final counted pulse. The bench therefore drives pulses at a falling edge and samples at the next falling edge, and it counts toggles across a known number of pulses. A ratio or source change costs one restart cycle, so the bench applies the change, spends that cycle (with or without a pulse, to show that the pulse is dropped) and only then counts. `test_out` and the enable gating are combinational from registered levels, so those checks sample 1 ns after the input changes.

// File: rtl/div_chain_pkg.sv
package div_chain_pkg;

    typedef enum logic [1:0] {
        NSEL_DIV2 = 2'b00,
        NSEL_DIV4 = 2'b01,
        NSEL_DIV8 = 2'b10,
        NSEL_DIV1 = 2'b11
    } nsel_e;

    typedef enum logic [2:0] {
        TSEL_SHIFT   = 3'b000,
        TSEL_ONE     = 3'b001,
        TSEL_REF     = 3'b010,
        TSEL_FB      = 3'b011,
        TSEL_OUT     = 3'b100,
        TSEL_ZERO    = 3'b101,
        TSEL_SCLK_FB = 3'b110,
        TSEL_OUT_Q   = 3'b111
    } tsel_e;

    localparam int NCNT_W = 3;

    // terminal count (ratio minus one) for an output ratio code
    function automatic logic [NCNT_W-1:0] n_terminal(input logic [1:0] code);
        logic [NCNT_W-1:0] t;
        case (nsel_e'(code))
            NSEL_DIV2: t = NCNT_W'(1);
            NSEL_DIV4: t = NCNT_W'(3);
            NSEL_DIV8: t = NCNT_W'(7);
            default:   t = NCNT_W'(0);
        endcase
        return t;
    endfunction

endpackage

// File: rtl/div_toggle_stage.sv
module div_toggle_stage #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          src_pulse,
    input  logic [CW-1:0] term,
    output logic          level,
    output logic          wrap
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lvl;
    } stage_t;

    stage_t st_d, st_q;
    logic   wrap_d;

    always_comb begin
        st_d   = st_q;
        wrap_d = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
        end else if (src_pulse) begin
            if (st_q.cnt == term) begin
                st_d.cnt = '0;
                st_d.lvl = ~st_q.lvl;
                wrap_d   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.lvl;
    assign wrap  = wrap_d;

endmodule

// File: rtl/div_test_sel.sv
module div_test_sel
    import div_chain_pkg::*;
(
    input  logic [2:0] sel,
    input  logic       shift_bit,
    input  logic       ref_lvl,
    input  logic       fb_lvl,
    input  logic       out_pin,
    input  logic       out_q_lvl,
    output logic       tst
);

    always_comb begin
        case (tsel_e'(sel))
            TSEL_SHIFT:   tst = shift_bit;
            TSEL_ONE:     tst = 1'b1;
            TSEL_REF:     tst = ref_lvl;
            TSEL_FB:      tst = fb_lvl;
            TSEL_OUT:     tst = out_pin;
            TSEL_ZERO:    tst = 1'b0;
            TSEL_SCLK_FB: tst = fb_lvl;
            default:      tst = out_q_lvl;
        endcase
    end

endmodule

// File: rtl/synth_div_chain.sv
module synth_div_chain
    import div_chain_pkg::*;
#(
    parameter int M_WIDTH          = 9,
    parameter int REF_RATIO        = 16,
    parameter int OUT_TEST_RATIO   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_pulse,
    input  logic               vco_pulse,
    input  logic               sclk_pulse,
    input  logic [M_WIDTH-1:0] m_val,
    input  logic [1:0]         n_code,
    input  logic [2:0]         test_sel,
    input  logic               shift_out,
    input  logic               out_en,
    output logic               ref_div_clk,
    output logic               fb_clk,
    output logic               out_clk,
    output logic               test_out
);

    localparam int REF_CW = $clog2(REF_RATIO);
    localparam int Q4_CW  = $clog2(OUT_TEST_RATIO);
    localparam logic [REF_CW-1:0] REF_TERM = REF_CW'(REF_RATIO - 1);
    localparam logic [Q4_CW-1:0]  Q4_TERM  = Q4_CW'(OUT_TEST_RATIO - 1);

    typedef struct packed {
        logic [M_WIDTH-1:0] m;
        logic [1:0]         n;
        logic               sclk_src;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic src_sel;
    logic div_pulse;
    logic m_restart;
    logic n_restart;
    logic m_wrap;
    logic n_wrap;
    logic out_lvl;
    logic out_q_lvl;
    logic ref_wrap_unused;
    logic fb_wrap_unused;
    logic q4_wrap_unused;

    assign src_sel   = (tsel_e'(test_sel) == TSEL_SCLK_FB);
    assign div_pulse = src_sel ? sclk_pulse : vco_pulse;
    assign m_restart = (m_val != cfg_q.m)  || (src_sel != cfg_q.sclk_src);
    assign n_restart = (n_code != cfg_q.n) || (src_sel != cfg_q.sclk_src);

    always_comb begin
        cfg_d          = cfg_q;
        cfg_d.m        = m_val;
        cfg_d.n        = n_code;
        cfg_d.sclk_src = src_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.m        <= '1;
            cfg_q.n        <= 2'b11;
            cfg_q.sclk_src <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // reference path: fixed ratio
    div_toggle_stage #(.CW(REF_CW)) u_ref (
        .clk(clk), .rst_n(rst_n), .restart(1'b0), .src_pulse(ref_pulse),
        .term(REF_TERM), .level(ref_div_clk), .wrap(ref_wrap_unused)
    );

    // feedback path: divide by M (terminal pulse), then by two
    div_toggle_stage #(.CW(M_WIDTH)) u_mdiv (
        .clk(clk), .rst_n(rst_n), .restart(m_restart), .src_pulse(div_pulse),
        .term(m_val - 1'b1), .level(), .wrap(m_wrap)
    );

    div_toggle_stage #(.CW(1)) u_fbhalf (
        .clk(clk), .rst_n(rst_n), .restart(m_restart), .src_pulse(m_wrap),
        .term(1'b1), .level(fb_clk), .wrap(fb_wrap_unused)
    );

    // output path: coded ratio, then the observation divider behind it
    div_toggle_stage #(.CW(NCNT_W)) u_ndiv (
        .clk(clk), .rst_n(rst_n), .restart(n_restart), .src_pulse(div_pulse),
        .term(n_terminal(n_code)), .level(out_lvl), .wrap(n_wrap)
    );

    div_toggle_stage #(.CW(Q4_CW)) u_outq (
        .clk(clk), .rst_n(rst_n), .restart(n_restart), .src_pulse(n_wrap),
        .term(Q4_TERM), .level(out_q_lvl), .wrap(q4_wrap_unused)
    );

    assign out_clk = out_en & out_lvl;

    div_test_sel u_tsel (
        .sel(test_sel), .shift_bit(shift_out), .ref_lvl(ref_div_clk),
        .fb_lvl(fb_clk), .out_pin(out_clk), .out_q_lvl(out_q_lvl), .tst(test_out)
    );

endmodule

// File: rtl/synth_div_chain_chk.sv
module synth_div_chain_chk #(
    parameter int M_WIDTH = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ref_pulse,
    input logic               vco_pulse,
    input logic               sclk_pulse,
    input logic [M_WIDTH-1:0] m_val,
    input logic [1:0]         n_code,
    input logic [2:0]         test_sel,
    input logic               shift_out,
    input logic               out_en,
    input logic               ref_div_clk,
    input logic               fb_clk,
    input logic               out_clk,
    input logic               test_out
);

    // R2
    ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_pulse |=> $stable(ref_div_clk));

    // R3
    fb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vco_pulse && !sclk_pulse) |=> $stable(fb_clk));

    // R5
    oe_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !out_clk);

    // R6
    tst_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_sel == 3'b001) |-> test_out);

    // R6
    tst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_sel == 3'b101) |-> !test_out);

    // R6
    tst_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_sel == 3'b000) |-> (test_out == shift_out));

    // R8
    n_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (n_code != $past(n_code)))
            |=> ($stable(out_clk) || !$stable(out_en)));

endmodule

bind synth_div_chain synth_div_chain_chk #(.M_WIDTH(M_WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .vco_pulse(vco_pulse),
    .sclk_pulse(sclk_pulse), .m_val(m_val), .n_code(n_code), .test_sel(test_sel),
    .shift_out(shift_out), .out_en(out_en), .ref_div_clk(ref_div_clk),
    .fb_clk(fb_clk), .out_clk(out_clk), .test_out(test_out)
);

// File: tb/synth_div_chain_test.sv
module synth_div_chain_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_pulse = 1'b0, vco_pulse = 1'b0, sclk_pulse = 1'b0;
    logic [8:0] m_val = 9'd3;
    logic [1:0] n_code = 2'b00;
    logic [2:0] test_sel = 3'b000;
    logic       shift_out = 1'b0;
    logic       out_en = 1'b1;
    logic       ref_div_clk, fb_clk, out_clk, test_out;

    always #5 clk = ~clk;

    synth_div_chain uut (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .vco_pulse(vco_pulse),
        .sclk_pulse(sclk_pulse), .m_val(m_val), .n_code(n_code), .test_sel(test_sel),
        .shift_out(shift_out), .out_en(out_en), .ref_div_clk(ref_div_clk),
        .fb_clk(fb_clk), .out_clk(out_clk), .test_out(test_out)
    );

    typedef struct packed {
        int m; int n; int t; int p; int e_out; int e_fb; int e_tst;
    } vec_t;

    // m, n code, test code, pulses, expected toggles of out / fb / test
    localparam vec_t VECS [0:7] = '{
        '{3,   0, 4, 48,   24,  8, 24},
        '{3,   1, 7, 48,   12,  8,  3},
        '{5,   2, 3, 60,    7,  6,  6},
        '{4,   3, 4, 24,   24,  3, 24},
        '{125, 0, 3, 500, 250,  2,  2},
        '{0,   2, 5, 1100,137,  1,  0},
        '{2,   3, 7, 20,   20,  5,  5},
        '{3,   0, 1, 12,    6,  2,  0}
    };

    int  n_chk = 0, n_bad = 0;
    bit  done = 1'b0;
    int  t_ref, t_fb, t_out, t_tst;
    logic p_ref, p_fb, p_out, p_tst;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_counts();
        t_ref = 0; t_fb = 0; t_out = 0; t_tst = 0;
        p_ref = ref_div_clk; p_fb = fb_clk; p_out = out_clk; p_tst = test_out;
    endtask

    task automatic step(input logic r, input logic v, input logic s);
        ref_pulse = r; vco_pulse = v; sclk_pulse = s;
        @(negedge clk);
        if (ref_div_clk != p_ref) t_ref++;
        if (fb_clk != p_fb)       t_fb++;
        if (out_clk != p_out)     t_out++;
        if (test_out != p_tst)    t_tst++;
        p_ref = ref_div_clk; p_fb = fb_clk; p_out = out_clk; p_tst = test_out;
        ref_pulse = 1'b0; vco_pulse = 1'b0; sclk_pulse = 1'b0;
    endtask

    task automatic run(input int k, input logic r, input logic v, input logic s);
        for (int i = 0; i < k; i++) step(r, v, s);
    endtask

    task automatic do_reset(input int m, input int n, input int t, input logic oe);
        m_val = m[8:0]; n_code = n[1:0]; test_sel = t[2:0]; out_en = oe;
        rst_n = 1'b0;
        step(0, 0, 0);
        step(0, 0, 0);
        rst_n = 1'b1;
        step(0, 0, 0);
        clear_counts();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);

        // R1 reset state and R6 shift-register pass-through
        do_reset(3, 0, 0, 1);
        check("R1 ref_div_clk after reset", ref_div_clk, 0);
        check("R1 fb_clk after reset", fb_clk, 0);
        check("R1 out_clk after reset", out_clk, 0);
        shift_out = 1'b1; #1;
        check("R6 code 000 shows shift_out=1", test_out, 1);
        shift_out = 1'b0; #1;
        check("R6 code 000 shows shift_out=0", test_out, 0);
        test_sel = 3'b001; #1;
        check("R6 code 001 constant high", test_out, 1);
        test_sel = 3'b101; #1;
        check("R6 code 101 constant low", test_out, 0);

        // vector table: R2 R3 R4 R6 R10
        for (int i = 0; i < 8; i++) begin
            do_reset(VECS[i].m, VECS[i].n, VECS[i].t, 1'b1);
            run(VECS[i].p, 1'b1, 1'b1, 1'b0);
            check($sformatf("R2 vec%0d ref toggles", i), t_ref, VECS[i].p / 16);
            check($sformatf("R4 vec%0d out toggles", i), t_out, VECS[i].e_out);
            check($sformatf("R3 vec%0d fb toggles", i), t_fb, VECS[i].e_fb);
            check($sformatf("R6/R10 vec%0d test toggles", i), t_tst, VECS[i].e_tst);
        end
        check("R6 code 001 holds high after run", test_out, 1);

        // R9 latency: the level changes at the edge after the K-th pulse
        do_reset(3, 0, 4, 1);
        step(0, 1, 0);
        check("R9 out after 1st pulse", out_clk, 0);
        step(0, 1, 0);
        check("R9 out after 2nd pulse", out_clk, 1);
        run(15, 1'b1, 1'b0, 1'b0);
        check("R9 ref after 15 pulses", ref_div_clk, 0);
        step(1, 0, 0);
        check("R9 ref after 16th pulse", ref_div_clk, 1);

        // R8 N change with a pulse in the change cycle
        do_reset(5, 2, 4, 1);
        run(5, 1'b0, 1'b1, 1'b0);
        n_code = 2'b00;
        step(0, 1, 0);
        check("R8 out held in restart cycle", out_clk, 0);
        step(0, 1, 0);
        check("R8 out after 1 pulse past restart", out_clk, 0);
        step(0, 1, 0);
        check("R8 out toggles 2 pulses past restart", out_clk, 1);

        // R8 M change
        do_reset(5, 0, 4, 1);
        run(3, 1'b0, 1'b1, 1'b0);
        m_val = 9'd2;
        step(0, 0, 0);
        run(3, 1'b0, 1'b1, 1'b0);
        check("R8 fb after 3 pulses past M restart", fb_clk, 0);
        step(0, 1, 0);
        check("R8 fb after 4 pulses past M restart", fb_clk, 1);

        // R7 serial-clock source selection
        do_reset(2, 1, 6, 1);
        run(8, 1'b0, 1'b1, 1'b0);
        check("R7 code 110 ignores vco: out", t_out, 0);
        check("R7 code 110 ignores vco: fb", t_fb, 0);
        run(8, 1'b0, 1'b0, 1'b1);
        check("R7 code 110 sclk drives out", t_out, 2);
        check("R7 code 110 sclk drives fb", t_fb, 2);
        check("R6 code 110 test follows fb", t_tst, 2);
        test_sel = 3'b100;
        step(0, 0, 0);
        clear_counts();
        run(8, 1'b0, 1'b0, 1'b1);
        check("R7 normal code ignores sclk", t_out, 0);
        run(8, 1'b0, 1'b1, 1'b0);
        check("R7 normal code counts vco", t_out, 2);

        // R5 enable gating, R10 divide-by-4 keeps running
        do_reset(3, 0, 7, 0);
        run(16, 1'b0, 1'b1, 1'b0);
        check("R5 out_clk low while disabled", out_clk, 0);
        check("R5 no out toggles while disabled", t_out, 0);
        check("R10 div4 runs while disabled", t_tst, 2);
        run(2, 1'b0, 1'b1, 1'b0);
        out_en = 1'b1; #1;
        check("R5 out_clk resumes running level", out_clk, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule